// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Fault Injection

This block sends command/status and data words on a dual-redundant serial avionics bus. It uses the standard framing: a three-bit-time sync, sixteen Manchester-coded data bits sent MSB first, and an odd parity bit, at 1 Mbit/s. Words come from a small internal queue. Each queue entry holds the 16-bit word, a flag that picks command/status or data sync, a bus select, and one fault descriptor. The descriptor is a 3-bit kind code plus a 6-bit argument whose meaning depends on the kind. With it, a test system can corrupt one chosen word: flip its parity, replace its sync with any half-bit pattern, hold one bit cell at a forced level, put an idle gap in front of it, or lengthen or shorten it by up to three bit cells.

All timing comes from a 4 MHz tick enable. Every second tick is a half-bit step (0.5 µs), and the line changes only at those steps. Words in the queue go out back to back. When the last queued word ends, an 8-bit response timer restarts and counts ticks (250 ns each) until it is halted. One serialiser serves both buses. The bus select only decides which of the two transmit enables is raised.

Top module: `mbus_tx_encoder`

## Requirements
- R1: After reset, tx_p, tx_n, tx_en_a and tx_en_b are 0, wr_ready is 1 and rsp_time is 0.
- R2: The first tick after reset does not make a half-bit step; every second tick after it does. A word without a sync fault starts with six half-bit cells. The pattern is high,high,high,low,low,low when wr_is_data=0 and low,low,low,high,high,high when wr_is_data=1.
- R3: After the sync come bit cells for wr_word[15] down to wr_word[0]. A one is sent as high then low, and a zero as low then high. Each cell is two half-bit steps. tx_n is the inverse of tx_p while a bus enable is high, and both are 0 otherwise. A queued word starts at the half-bit step that ends the previous word, with no idle cell in between.
- R4: The seventeenth bit cell carries odd parity over the 16 data bits.
- R5: Kind code 1 inverts the parity cell of that word only.
- R6: Kind code 2 replaces the sync with wr_err_arg[5:0], six half-bit levels sent from bit 5 down to bit 0.
- R7: Kind code 3 forces the level wr_err_arg[5] on both halves of the bit cell at position wr_err_arg[4:0]. Position 0 is the cell of wr_word[15], and position 16 is the parity cell.
- R8: Kind code 4 puts wr_err_arg[3:0] idle half-bit steps (0.5 µs each, so 0.5 to 7.5 µs) in front of that word's sync. Both enables are low during the gap. A count of 0 puts in no gap.
- R9: Kind code 5 changes the number of bit cells from 17 by the two's-complement value wr_err_arg[2:0] (-3 to +3; the code 3'b100 means no change). Cells are removed from the end, and added cells carry logic zero. Kind codes 0, 6 and 7 inject no fault.
- R10: wr_bus is taken per word. While the word is sent, tx_en_a is high for wr_bus=0 and tx_en_b is high for wr_bus=1, and never both at once.
- R11: The queue holds DEPTH (default 4) entries. wr_ready is low while it is full, and words go out in the order they were written.
- R12: rsp_time becomes 0 at the step that ends the last queued word. It then rises by one on each later tick, stops at 255, and freezes when rsp_stop is high or when a new transmission starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 4 MHz timing enable |
| wr_valid | input | 1 | Queue write request |
| wr_ready | output | 1 | Queue has room |
| wr_word | input | 16 | Word to send |
| wr_is_data | input | 1 | 1 selects data sync, 0 selects command/status sync |
| wr_bus | input | 1 | 0 selects bus A, 1 selects bus B |
| wr_err_kind | input | 3 | Fault kind code |
| wr_err_arg | input | 6 | Fault argument |
| rsp_stop | input | 1 | Freezes the response timer |
| tx_p | output | 1 | True line drive |
| tx_n | output | 1 | Complement line drive |
| tx_en_a | output | 1 | Transmit enable, bus A |
| tx_en_b | output | 1 | Transmit enable, bus B |
| rsp_time | output | 8 | Response timer, 250 ns per count |

## Verification
The line outputs change one clock after an edge at which tick_en is high on an odd phase. A queued word begins at the first such step after the edge that wrote it. The bench model keeps its own half-bit symbol stream and tick phase, and advances them at the same rising edges from the inputs it drives. rsp_time moves one clock after a tick edge, or one clock after the closing step. Inputs are driven on falling edges, and both the line and the timer are compared with the model on every falling edge, so each result is checked in the cycle it is due.

// File: rtl/mbus_tx_pkg.sv
package mbus_tx_pkg;

    localparam int WORD_W      = 16;
    localparam int ARG_W       = 6;
    localparam int SYNC_HALVES = 6;
    localparam int BASE_CELLS  = WORD_W + 1;
    localparam int CELL_W      = 5;
    localparam int CNT_W       = CELL_W + 1;

    localparam logic [2:0] K_NONE   = 3'd0;
    localparam logic [2:0] K_PAR    = 3'd1;
    localparam logic [2:0] K_SYNC   = 3'd2;
    localparam logic [2:0] K_STUCK  = 3'd3;
    localparam logic [2:0] K_GAP    = 3'd4;
    localparam logic [2:0] K_BITCNT = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_SYNC,
        ST_BITS
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              is_data;
        logic              bus;
        logic [2:0]        kind;
        logic [ARG_W-1:0]  arg;
    } tx_entry_t;

    localparam int ENTRY_W = $bits(tx_entry_t);

    function automatic logic odd_parity(input logic [WORD_W-1:0] w);
        return ~^w;
    endfunction

    function automatic logic [SYNC_HALVES-1:0] std_sync(input logic is_data);
        return is_data ? 6'b000111 : 6'b111000;
    endfunction

    // number of bit cells in a word, including the bit-count fault
    function automatic logic [CELL_W-1:0] cell_count(input tx_entry_t e);
        logic [CELL_W:0] d;
        logic [CELL_W:0] s;
        d = {{(CELL_W-2){e.arg[2]}}, e.arg[2:0]};
        s = (CELL_W+1)'(BASE_CELLS);
        if (e.kind == K_BITCNT && e.arg[2:0] != 3'b100)
            s = s + d;
        return s[CELL_W-1:0];
    endfunction

endpackage

// File: rtl/mbus_tx_fifo.sv
module mbus_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R11
    fifo_pop_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/mbus_rsp_timer.sv
module mbus_rsp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic         halt,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MAXV = '1;

    logic run;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            run   <= 1'b0;
        end else if (clear) begin
            value <= '0;
            run   <= 1'b1;
        end else if (halt) begin
            run   <= 1'b0;
        end else if (tick && run && value != MAXV) begin
            value <= value + W'(1);
        end
    end

    // R12
    rsp_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (value == MAXV && !clear) |=> value == MAXV);

    // R12
    rsp_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> value >= $past(value));

endmodule

// File: rtl/mbus_tx_seq.sv
module mbus_tx_seq
    import mbus_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      head_valid,
    input  tx_entry_t head,
    output logic      take,
    output logic      line_p,
    output logic      line_en,
    output logic      line_bus,
    output logic      go_idle,
    output logic      start_tx
);
    logic                   phase;
    logic                   hs;
    seq_state_e             st;
    logic [CNT_W-1:0]       cnt;
    tx_entry_t              cur;
    logic [CELL_W-1:0]      cells;
    logic [CNT_W-1:0]       last_half;
    logic                   word_done;

    logic [SYNC_HALVES-1:0] sync_pat;
    logic [SYNC_HALVES-1:0] sync_sh;
    logic [CELL_W-1:0]      bidx;
    logic [WORD_W-1:0]      wsh;
    logic                   dbit;
    logic                   cellv;

    assign hs        = tick & phase;
    assign cells     = cell_count(cur);
    assign last_half = {cells, 1'b0} - CNT_W'(1);
    assign word_done = (st == ST_BITS) && (cnt == last_half);
    assign take      = hs && head_valid && (st == ST_IDLE || word_done);
    assign go_idle   = hs && word_done && !head_valid;
    assign start_tx  = take && (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst)       phase <= 1'b0;
        else if (tick) phase <= ~phase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            cur <= '0;
        end else if (take) begin
            cur <= head;
            if (head.kind == K_GAP && head.arg[3:0] != 4'd0) begin
                st  <= ST_GAP;
                cnt <= CNT_W'(head.arg[3:0]) - CNT_W'(1);
            end else begin
                st  <= ST_SYNC;
                cnt <= '0;
            end
        end else if (hs) begin
            case (st)
                ST_GAP: begin
                    if (cnt == '0) st <= ST_SYNC;
                    else           cnt <= cnt - CNT_W'(1);
                end
                ST_SYNC: begin
                    if (cnt == CNT_W'(SYNC_HALVES - 1)) begin
                        st  <= ST_BITS;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_BITS: begin
                    if (word_done) st <= ST_IDLE;
                    else           cnt <= cnt + CNT_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sync_pat = (cur.kind == K_SYNC) ? cur.arg : std_sync(cur.is_data);
        sync_sh  = sync_pat << cnt;
        bidx     = cnt[CNT_W-1:1];
        wsh      = cur.word << bidx;
        if (bidx < CELL_W'(WORD_W))
            dbit = wsh[WORD_W-1];
        else if (bidx == CELL_W'(WORD_W))
            dbit = odd_parity(cur.word) ^ (cur.kind == K_PAR);
        else
            dbit = 1'b0;
        cellv = cnt[0] ? ~dbit : dbit;
        if (cur.kind == K_STUCK && bidx == cur.arg[4:0])
            cellv = cur.arg[5];
        line_p  = 1'b0;
        line_en = 1'b0;
        case (st)
            ST_SYNC: begin
                line_en = 1'b1;
                line_p  = sync_sh[SYNC_HALVES-1];
            end
            ST_BITS: begin
                line_en = 1'b1;
                line_p  = cellv;
            end
            default: ;
        endcase
    end

    assign line_bus = cur.bus;

    // R3
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hs |=> ($stable(line_p) && $stable(line_en)));

    // R2
    sync_span_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SYNC && hs && cnt == CNT_W'(SYNC_HALVES - 1)) |=> st == ST_BITS);

    // R8
    gap_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |=> (st == ST_GAP || st == ST_SYNC));

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(line_bus));

endmodule

// File: rtl/mbus_tx_encoder.sv
module mbus_tx_encoder
    import mbus_tx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int RSP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_is_data,
    input  logic              wr_bus,
    input  logic [2:0]        wr_err_kind,
    input  logic [ARG_W-1:0]  wr_err_arg,
    input  logic              rsp_stop,
    output logic              tx_p,
    output logic              tx_n,
    output logic              tx_en_a,
    output logic              tx_en_b,
    output logic [RSP_W-1:0]  rsp_time
);
    tx_entry_t          in_e;
    tx_entry_t          head;
    logic [ENTRY_W-1:0] head_raw;
    logic               q_empty, q_full, push, take;
    logic               line_p, line_en, line_bus, go_idle, start_tx;

    assign in_e = '{word: wr_word, is_data: wr_is_data, bus: wr_bus,
                    kind: wr_err_kind, arg: wr_err_arg};
    assign push     = wr_valid & ~q_full;
    assign wr_ready = ~q_full;
    assign head     = tx_entry_t'(head_raw);

    mbus_tx_fifo #(.DW(ENTRY_W), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .push(push), .din(in_e), .pop(take),
        .dout(head_raw), .empty(q_empty), .full(q_full)
    );

    mbus_tx_seq u_seq (
        .clk(clk), .rst(rst), .tick(tick_en), .head_valid(~q_empty), .head(head),
        .take(take), .line_p(line_p), .line_en(line_en), .line_bus(line_bus),
        .go_idle(go_idle), .start_tx(start_tx)
    );

    mbus_rsp_timer #(.W(RSP_W)) u_rsp (
        .clk(clk), .rst(rst), .tick(tick_en), .clear(go_idle),
        .halt(rsp_stop | start_tx), .value(rsp_time)
    );

    assign tx_p    = line_en & line_p;
    assign tx_n    = line_en & ~line_p;
    assign tx_en_a = line_en & ~line_bus;
    assign tx_en_b = line_en & line_bus;

endmodule

// File: tb/sim_mbus_tx_encoder.sv
module sim_mbus_tx_encoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_word = '0;
    logic        wr_is_data = 1'b0;
    logic        wr_bus = 1'b0;
    logic [2:0]  wr_err_kind = '0;
    logic [5:0]  wr_err_arg = '0;
    logic        rsp_stop = 1'b0;
    logic        tx_p, tx_n, tx_en_a, tx_en_b;
    logic [7:0]  rsp_time;

    always #2 clk = ~clk;

    mbus_tx_encoder u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_word(wr_word), .wr_is_data(wr_is_data), .wr_bus(wr_bus),
        .wr_err_kind(wr_err_kind), .wr_err_arg(wr_err_arg), .rsp_stop(rsp_stop),
        .tx_p(tx_p), .tx_n(tx_n), .tx_en_a(tx_en_a), .tx_en_b(tx_en_b), .rsp_time(rsp_time)
    );

    typedef struct packed {
        logic       gap;
        logic       p;
        logic       bus;
        logic [3:0] tag;
    } sym_t;

    sym_t q[$];
    sym_t cur;
    bit   busy = 0;
    bit   mph = 0;
    int   tval = 0;
    bit   trun = 0;
    int   total = 0;
    int   bad = 0;
    int   cycles = 0;
    bit   finished = 0;

    function automatic string tname(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input bit ok, input int tagn, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tname(tagn), what, act, exp);
        end
    endtask

    // behavioural symbol list of one word, built from the requirements
    task automatic add_word(input logic [15:0] w, input logic isd, input logic bs,
                            input logic [2:0] k, input logic [5:0] a);
        sym_t s;
        logic [5:0] pat;
        int nb, d, tg;
        logic v, lv;
        s.bus = bs;
        if (k == 3'd4 && a[3:0] != 4'd0)
            for (int i = 0; i < int'(a[3:0]); i++) begin
                s.gap = 1; s.p = 0; s.tag = 4'd8; q.push_back(s);
            end
        pat = (k == 3'd2) ? a : (isd ? 6'b000111 : 6'b111000);
        for (int i = 0; i < 6; i++) begin
            s.gap = 0; s.p = pat[5-i]; s.tag = (k == 3'd2) ? 4'd6 : 4'd2; q.push_back(s);
        end
        nb = 17;
        if (k == 3'd5 && a[2:0] != 3'b100) begin
            d = a[2] ? int'(a[2:0]) - 8 : int'(a[2:0]);
            nb = 17 + d;
        end
        for (int b = 0; b < nb; b++) begin
            if (b < 16)       begin v = w[15-b]; tg = 3; end
            else if (b == 16) begin v = ((^w) == 1'b0) ^ (k == 3'd1); tg = (k == 3'd1) ? 5 : 4; end
            else              begin v = 1'b0; tg = 9; end
            if (k == 3'd5) tg = 9;
            for (int h = 0; h < 2; h++) begin
                lv = h ? !v : v;
                s.tag = 4'(tg);
                if (k == 3'd3 && b == int'(a[4:0])) begin lv = a[5]; s.tag = 4'd7; end
                s.gap = 0; s.p = lv; q.push_back(s);
            end
        end
    endtask

    // cycle model: half-bit stream and response timer
    always @(posedge clk) begin
        bit mhs, was, entered, left;
        cycles++;
        if (rst) begin
            mph = 0; busy = 0; cur = '0; tval = 0; trun = 0; q.delete();
        end else begin
            mhs = tick_en && mph;
            if (tick_en) mph = !mph;
            was = busy;
            if (mhs) begin
                if (q.size() > 0) begin cur = q.pop_front(); busy = 1; end
                else busy = 0;
            end
            entered = was && !busy;
            left = !was && busy;
            if (entered) begin tval = 0; trun = 1; end
            else if (rsp_stop || left) trun = 0;
            else if (tick_en && trun && tval < 255) tval++;
            if (wr_valid) add_word(wr_word, wr_is_data, wr_bus, wr_err_kind, wr_err_arg);
        end
        if (cycles > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R3 watchdog act=%0d exp=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic [3:0] act, exp;
        if (!rst) begin
            act = {tx_p, tx_n, tx_en_a, tx_en_b};
            exp = (busy && !cur.gap) ? {cur.p, !cur.p, !cur.bus, cur.bus} : 4'b0000;
            chk(act == exp, busy ? int'(cur.tag) : 3, "line", int'(act), int'(exp));
            chk(int'(rsp_time) == tval, 12, "rsp_time", int'(rsp_time), tval);
        end
    end

    initial begin
        tick_en = 1'b0;
        forever begin
            @(negedge clk);
            tick_en = rst ? 1'b0 : ~tick_en;
        end
    end

    task automatic push(input logic [15:0] w, input logic isd, input logic bs,
                        input logic [2:0] k, input logic [5:0] a);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1; wr_word = w; wr_is_data = isd; wr_bus = bs; wr_err_kind = k; wr_err_arg = a;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic wait_idle(input int extra);
        while (busy || q.size() != 0) @(negedge clk);
        repeat (extra) @(negedge clk);
    endtask

    task automatic wait_on_line();
        while (!(busy && !cur.gap)) @(negedge clk);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({tx_p, tx_n, tx_en_a, tx_en_b} == 4'b0, 1, "idle line", int'({tx_p, tx_n, tx_en_a, tx_en_b}), 0);
        chk(wr_ready == 1'b1, 1, "wr_ready", int'(wr_ready), 1);
        chk(rsp_time == 8'd0, 1, "rsp_time", int'(rsp_time), 0);

        // R2 R3 R4 plain words, command and data sync, both buses
        push(16'hA5C3, 0, 0, 3'd0, 6'd0);
        wait_idle(6);
        push(16'h0000, 1, 1, 3'd0, 6'd0);
        wait_on_line();
        // R10 bus B enable only
        chk(tx_en_b && !tx_en_a, 10, "bus B enable", int'({tx_en_a, tx_en_b}), 1);
        wait_idle(3);
        push(16'hFFFF, 0, 0, 3'd6, 6'h3F);   // kind 6 injects nothing (R9)
        push(16'h8001, 1, 0, 3'd0, 6'd0);
        wait_idle(5);

        // R5 parity flip on a single word between clean ones
        push(16'h1234, 0, 0, 3'd0, 6'd0);
        push(16'h1234, 1, 1, 3'd1, 6'd0);
        push(16'h1234, 1, 0, 3'd0, 6'd0);
        wait_idle(4);

        // R6 custom sync patterns
        push(16'h5555, 0, 1, 3'd2, 6'b101010);
        push(16'hAAAA, 1, 1, 3'd2, 6'b000000);
        wait_idle(4);

        // R7 stuck cells at first bit, parity and middle
        push(16'h0F0F, 0, 0, 3'd3, 6'b1_00000);
        push(16'h0F0F, 1, 0, 3'd3, 6'b0_10000);
        push(16'hFFFF, 1, 1, 3'd3, 6'b0_00111);
        wait_idle(4);

        // R8 gaps of maximum, minimum and zero
        push(16'h7E7E, 0, 0, 3'd0, 6'd0);
        push(16'h7E7E, 1, 0, 3'd4, 6'd15);
        push(16'h0001, 1, 1, 3'd4, 6'd1);
        push(16'h0002, 1, 1, 3'd4, 6'd0);
        wait_idle(4);

        // R9 bit count longer, shorter, neutral code
        push(16'hC3C3, 0, 0, 3'd5, 6'd3);
        push(16'hC3C3, 1, 0, 3'd5, 6'b000101);
        push(16'h3C3C, 1, 1, 3'd5, 6'b000100);
        wait_idle(4);

        // R11 queue fills while a word is on the line
        push(16'h1111, 0, 0, 3'd0, 6'd0);
        wait_on_line();
        push(16'h2222, 1, 0, 3'd0, 6'd0);
        push(16'h3333, 1, 1, 3'd0, 6'd0);
        push(16'h4444, 1, 0, 3'd1, 6'd0);
        push(16'h5555, 1, 1, 3'd0, 6'd0);
        chk(wr_ready == 1'b0, 11, "full queue ready", int'(wr_ready), 0);
        push(16'h6666, 0, 0, 3'd0, 6'd0);
        wait_idle(2);

        // R12 timer saturates after a long quiet time
        repeat (600) @(negedge clk);
        chk(rsp_time == 8'd255, 12, "saturation", int'(rsp_time), 255);

        // R12 timer restarts, then freezes on rsp_stop
        push(16'h9999, 0, 0, 3'd0, 6'd0);
        wait_idle(21);
        rsp_stop = 1;
        @(negedge clk);
        rsp_stop = 0;
        v = int'(rsp_time);
        repeat (40) @(negedge clk);
        chk(int'(rsp_time) == v, 12, "frozen", int'(rsp_time), v);
        chk(v > 0 && v < 20, 12, "restart count", v, 10);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule